// File: doc/BRIEF.md
# Keystream Core Register Front End

This block puts a keystream generator core behind a small synchronous host bus. The host writes eight key words, two IV words, a key-size flag, a round count and sixteen input words into a register bank. Each of these fields is driven continuously onto the core-side ports. The host starts a block by writing a command register, then polls a status word until the core reports ready. After that it reads the 512-bit result back as sixteen 32-bit words. The cipher arithmetic is not part of this block: the core sits outside it, behind plain command, parameter and result ports.

A bus access is a single cycle in which `bus_cs` is high. `bus_we` picks a write (1) or a read (0). Writes land on the clock edge at the end of that cycle. Read data is combinational, valid in the same cycle, and 0 whenever no read is in progress. The bus has no back-pressure: every access completes in its own cycle. The core ports carry no handshake either. The command bits reach the core as one-cycle pulses, and the core answers through its level-sensitive ready and valid flags.

Top module: `kstream_regif`

## Requirements
- R1: After the active-low reset, every stored register reads 0 and the core-side parameter, data and command outputs are 0.
- R2: Key words sit at addresses 0x10 to 0x17. Word k drives `core_key[255-32k -: 32]`, so word 0 is the most significant, and each word reads back at its own address.
- R3: IV word 0 at 0x20 drives `core_iv[63:32]` and IV word 1 at 0x21 drives `core_iv[31:0]`. Both read back.
- R4: Input words sit at 0x40 to 0x4f. Word k drives `core_din[511-32k -: 32]` and reads back.
- R5: The key-size flag at 0x0a keeps only write-data bit 0, and the round count at 0x0b keeps only bits 4:0. Both read back zero-extended to 32 bits.
- R6: The command register at 0x08 keeps bits 1:0 and reads them back. A write with bit 0 set raises `core_start`, and a write with bit 1 set raises `core_advance`. Each pulse lasts exactly the one cycle after the write edge, even while the register keeps the bit.
- R7: A read of the status word at 0x09 returns `core_ready` in bit 0 and `core_valid` in bit 1, with all other bits 0.
- R8: A read of address 0x80+k, for k from 0 to 15, returns `core_result[511-32k -: 32]`.
- R9: Addresses 0x00 and 0x01 read the name words 0x6b737472 and 0x65676966, and 0x02 reads the version word 0x302e3930.
- R10: A read of any other address returns 0. A write to a read-only or unmapped address changes no register.
- R11: While `bus_cs` is low, `bus_rdata` is 0 and a raised `bus_we` writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs | input | 1 | Access select for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| core_start | output | 1 | One-cycle start-of-stream command |
| core_advance | output | 1 | One-cycle next-block command |
| core_key | output | 256 | Key, word 0 most significant |
| core_iv | output | 64 | IV, word 0 most significant |
| core_key_wide | output | 1 | 1 selects a 256-bit key, 0 a 128-bit key |
| core_rounds | output | 5 | Round count |
| core_din | output | 512 | Input block, word 0 most significant |
| core_ready | input | 1 | Core is idle and its result is usable |
| core_valid | input | 1 | Core result is valid |
| core_result | input | 512 | Core output block |

## Verification
A read is due in the same cycle it is issued, so the bench drives address and select just after a falling edge and samples `bus_rdata` a quarter period later, before the next rising edge. A written value is due on the core-side ports and on readback from the rising edge that ends the write cycle. The bench therefore samples those one falling edge after the write. A command pulse is due in the single cycle after the write edge. It is sampled high at the first falling edge after the write and low at the second, while the command register still holds the bit.

// File: rtl/kstream_regif_pkg.sv
package kstream_regif_pkg;
  // Host map (word addresses)
  localparam logic [7:0] ADR_NAME0    = 8'h00;
  localparam logic [7:0] ADR_NAME1    = 8'h01;
  localparam logic [7:0] ADR_VERSION  = 8'h02;
  localparam logic [7:0] ADR_CMD      = 8'h08;
  localparam logic [7:0] ADR_STATUS   = 8'h09;
  localparam logic [7:0] ADR_KEYSIZE  = 8'h0a;
  localparam logic [7:0] ADR_ROUNDS   = 8'h0b;
  localparam logic [7:0] ADR_KEY_BASE = 8'h10;
  localparam logic [7:0] ADR_IV_BASE  = 8'h20;
  localparam logic [7:0] ADR_DIN_BASE = 8'h40;
  localparam logic [7:0] ADR_RES_BASE = 8'h80;

  // Command and status bit positions
  localparam int CMD_START_BIT = 0;
  localparam int CMD_ADV_BIT   = 1;
  localparam int STAT_RDY_BIT  = 0;
  localparam int STAT_VLD_BIT  = 1;

  // Identification words, ASCII, first character in the top byte
  localparam logic [31:0] ID_NAME0   = 32'h6b737472;
  localparam logic [31:0] ID_NAME1   = 32'h65676966;
  localparam logic [31:0] ID_VERSION = 32'h302e3930;
endpackage

// File: rtl/kstream_regif_store.sv
module kstream_regif_store
  import kstream_regif_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int KEY_WORDS = 8,
  parameter int IV_WORDS  = 2,
  parameter int BLK_WORDS = 16,
  parameter int ROUND_W   = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [WORD_W-1:0]             wdata,
  output logic [KEY_WORDS*WORD_W-1:0]   key_flat,
  output logic [IV_WORDS*WORD_W-1:0]    iv_flat,
  output logic [BLK_WORDS*WORD_W-1:0]   din_flat,
  output logic                          key_wide,
  output logic [ROUND_W-1:0]            rounds,
  output logic [1:0]                    cmd
);
  logic [WORD_W-1:0] key_q [KEY_WORDS];
  logic [WORD_W-1:0] iv_q  [IV_WORDS];
  logic [WORD_W-1:0] din_q [BLK_WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < KEY_WORDS; i++) key_q[i] <= '0;
      for (int i = 0; i < IV_WORDS; i++)  iv_q[i]  <= '0;
      for (int i = 0; i < BLK_WORDS; i++) din_q[i] <= '0;
      key_wide <= 1'b0;
      rounds   <= '0;
      cmd      <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < KEY_WORDS; i++)
        if (int'(addr) == int'(ADR_KEY_BASE) + i) key_q[i] <= wdata;
      for (int i = 0; i < IV_WORDS; i++)
        if (int'(addr) == int'(ADR_IV_BASE) + i) iv_q[i] <= wdata;
      for (int i = 0; i < BLK_WORDS; i++)
        if (int'(addr) == int'(ADR_DIN_BASE) + i) din_q[i] <= wdata;
      if (int'(addr) == int'(ADR_KEYSIZE)) key_wide <= wdata[0];
      if (int'(addr) == int'(ADR_ROUNDS))  rounds   <= wdata[ROUND_W-1:0];
      if (int'(addr) == int'(ADR_CMD))     cmd      <= wdata[1:0];
    end
  end

  // Word 0 of each field lands in the most significant slice
  for (genvar g = 0; g < KEY_WORDS; g++) begin : g_key
    assign key_flat[(KEY_WORDS-1-g)*WORD_W +: WORD_W] = key_q[g];
  end
  for (genvar g = 0; g < IV_WORDS; g++) begin : g_iv
    assign iv_flat[(IV_WORDS-1-g)*WORD_W +: WORD_W] = iv_q[g];
  end
  for (genvar g = 0; g < BLK_WORDS; g++) begin : g_din
    assign din_flat[(BLK_WORDS-1-g)*WORD_W +: WORD_W] = din_q[g];
  end
endmodule

// File: rtl/kstream_regif_cmd.sv
module kstream_regif_cmd
  import kstream_regif_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic              start_pulse,
  output logic              adv_pulse
);
  logic cmd_hit;
  assign cmd_hit = wr_en && (int'(addr) == int'(ADR_CMD));

  // Pulses follow the write, not the stored level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_pulse <= 1'b0;
      adv_pulse   <= 1'b0;
    end else begin
      start_pulse <= cmd_hit && wdata[CMD_START_BIT];
      adv_pulse   <= cmd_hit && wdata[CMD_ADV_BIT];
    end
  end
endmodule

// File: rtl/kstream_regif_rdmux.sv
module kstream_regif_rdmux
  import kstream_regif_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int KEY_WORDS = 8,
  parameter int IV_WORDS  = 2,
  parameter int BLK_WORDS = 16,
  parameter int ROUND_W   = 5
) (
  input  logic                        rd_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [KEY_WORDS*WORD_W-1:0] key_flat,
  input  logic [IV_WORDS*WORD_W-1:0]  iv_flat,
  input  logic [BLK_WORDS*WORD_W-1:0] din_flat,
  input  logic                        key_wide,
  input  logic [ROUND_W-1:0]          rounds,
  input  logic [1:0]                  cmd,
  input  logic                        core_ready,
  input  logic                        core_valid,
  input  logic [BLK_WORDS*WORD_W-1:0] core_result,
  output logic [WORD_W-1:0]           rdata
);
  int a;
  assign a = int'(addr);

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (a == int'(ADR_NAME0))        rdata = ID_NAME0;
      else if (a == int'(ADR_NAME1))   rdata = ID_NAME1;
      else if (a == int'(ADR_VERSION)) rdata = ID_VERSION;
      else if (a == int'(ADR_CMD))     rdata = WORD_W'(cmd);
      else if (a == int'(ADR_STATUS)) begin
        rdata[STAT_RDY_BIT] = core_ready;
        rdata[STAT_VLD_BIT] = core_valid;
      end
      else if (a == int'(ADR_KEYSIZE)) rdata = WORD_W'(key_wide);
      else if (a == int'(ADR_ROUNDS))  rdata = WORD_W'(rounds);
      else if (a >= int'(ADR_KEY_BASE) && a < int'(ADR_KEY_BASE) + KEY_WORDS)
        rdata = key_flat[(KEY_WORDS-1-(a-int'(ADR_KEY_BASE)))*WORD_W +: WORD_W];
      else if (a >= int'(ADR_IV_BASE) && a < int'(ADR_IV_BASE) + IV_WORDS)
        rdata = iv_flat[(IV_WORDS-1-(a-int'(ADR_IV_BASE)))*WORD_W +: WORD_W];
      else if (a >= int'(ADR_DIN_BASE) && a < int'(ADR_DIN_BASE) + BLK_WORDS)
        rdata = din_flat[(BLK_WORDS-1-(a-int'(ADR_DIN_BASE)))*WORD_W +: WORD_W];
      else if (a >= int'(ADR_RES_BASE) && a < int'(ADR_RES_BASE) + BLK_WORDS)
        rdata = core_result[(BLK_WORDS-1-(a-int'(ADR_RES_BASE)))*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/kstream_regif.sv
module kstream_regif #(
  parameter int WORD_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int KEY_WORDS = 8,
  parameter int IV_WORDS  = 2,
  parameter int BLK_WORDS = 16,
  parameter int ROUND_W   = 5,
  localparam int KEY_W    = KEY_WORDS * WORD_W,
  localparam int IV_W     = IV_WORDS * WORD_W,
  localparam int BLK_W    = BLK_WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cs,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              core_start,
  output logic              core_advance,
  output logic [KEY_W-1:0]  core_key,
  output logic [IV_W-1:0]   core_iv,
  output logic              core_key_wide,
  output logic [ROUND_W-1:0] core_rounds,
  output logic [BLK_W-1:0]  core_din,
  input  logic              core_ready,
  input  logic              core_valid,
  input  logic [BLK_W-1:0]  core_result
);
  logic       wr_en;
  logic       rd_en;
  logic [1:0] cmd_q;

  assign wr_en = bus_cs && bus_we;
  assign rd_en = bus_cs && !bus_we;

  kstream_regif_store #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .KEY_WORDS(KEY_WORDS),
    .IV_WORDS(IV_WORDS), .BLK_WORDS(BLK_WORDS), .ROUND_W(ROUND_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(bus_addr), .wdata(bus_wdata),
    .key_flat(core_key), .iv_flat(core_iv), .din_flat(core_din),
    .key_wide(core_key_wide), .rounds(core_rounds), .cmd(cmd_q)
  );

  kstream_regif_cmd #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(bus_addr), .wdata(bus_wdata),
    .start_pulse(core_start), .adv_pulse(core_advance)
  );

  kstream_regif_rdmux #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .KEY_WORDS(KEY_WORDS),
    .IV_WORDS(IV_WORDS), .BLK_WORDS(BLK_WORDS), .ROUND_W(ROUND_W)
  ) u_rdmux (
    .rd_en(rd_en), .addr(bus_addr), .key_flat(core_key), .iv_flat(core_iv),
    .din_flat(core_din), .key_wide(core_key_wide), .rounds(core_rounds),
    .cmd(cmd_q), .core_ready(core_ready), .core_valid(core_valid),
    .core_result(core_result), .rdata(bus_rdata)
  );
endmodule

// File: rtl/kstream_regif_chk.sv
module kstream_regif_chk
  import kstream_regif_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 8,
  parameter int KEY_W  = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_cs,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [WORD_W-1:0] bus_wdata,
  input logic [WORD_W-1:0] bus_rdata,
  input logic              core_start,
  input logic              core_advance,
  input logic [KEY_W-1:0]  core_key,
  input logic              core_ready,
  input logic              core_valid
);
  logic cmd_wr;
  assign cmd_wr = bus_cs && bus_we && (int'(bus_addr) == int'(ADR_CMD));

  p_start_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && bus_wdata[CMD_START_BIT]) |=> core_start);
  p_start_caused_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_start) |-> $past(cmd_wr && bus_wdata[CMD_START_BIT]));
  p_adv_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && bus_wdata[CMD_ADV_BIT]) |=> core_advance);
  p_adv_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_wr && bus_wdata[CMD_ADV_BIT]) |=> !core_advance);
  p_idle_rdata_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_cs |-> (bus_rdata == '0));
  p_status_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cs && !bus_we && int'(bus_addr) == int'(ADR_STATUS))
      |-> (bus_rdata == WORD_W'({core_valid, core_ready})));
  p_key_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_cs && bus_we) |=> $stable(core_key));
endmodule

bind kstream_regif kstream_regif_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .core_start(core_start), .core_advance(core_advance), .core_key(core_key),
  .core_ready(core_ready), .core_valid(core_valid)
);

// File: tb/kstream_regif_test.sv
module kstream_regif_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_cs = 1'b0;
  logic         bus_we = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         core_start, core_advance, core_key_wide;
  logic [255:0] core_key;
  logic [63:0]  core_iv;
  logic [4:0]   core_rounds;
  logic [511:0] core_din;
  logic         core_ready = 1'b0;
  logic         core_valid = 1'b0;
  logic [511:0] core_result = '0;

  int n_chk = 0;
  int n_err = 0;

  // bench model of host-visible state
  logic [31:0] m_key [8];
  logic [31:0] m_iv  [2];
  logic [31:0] m_din [16];
  logic        m_wide;
  logic [4:0]  m_rounds;
  logic [1:0]  m_cmd;

  always #10 clk = ~clk;

  kstream_regif uut (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .core_start(core_start), .core_advance(core_advance), .core_key(core_key),
    .core_iv(core_iv), .core_key_wide(core_key_wide), .core_rounds(core_rounds),
    .core_din(core_din), .core_ready(core_ready), .core_valid(core_valid),
    .core_result(core_result)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int a);
    pat = {a[7:0], ~a[7:0], a[7:0] ^ 8'h5a, 8'hc3};
  endfunction

  function automatic logic [31:0] res_word(input int k);
    res_word = {8'ha0 + k[7:0], 8'h55, k[7:0], ~k[7:0]};
  endfunction

  function automatic string tag_of(input int a);
    if (a <= 2) return "R9";
    if (a == 8) return "R6";
    if (a == 9) return "R7";
    if (a == 10 || a == 11) return "R5";
    if (a >= 16 && a < 24) return "R2";
    if (a == 32 || a == 33) return "R3";
    if (a >= 64 && a < 80) return "R4";
    if (a >= 128 && a < 144) return "R8";
    return "R10";
  endfunction

  function automatic logic [31:0] exp_rd(input int a);
    case (a)
      0: return 32'h6b737472;
      1: return 32'h65676966;
      2: return 32'h302e3930;
      8: return {30'd0, m_cmd};
      9: return {30'd0, core_valid, core_ready};
      10: return {31'd0, m_wide};
      11: return {27'd0, m_rounds};
      default: begin
        if (a >= 16 && a < 24)   return m_key[a-16];
        if (a == 32 || a == 33)  return m_iv[a-32];
        if (a >= 64 && a < 80)   return m_din[a-64];
        if (a >= 128 && a < 144) return res_word(a-128);
        return 32'h0;
      end
    endcase
  endfunction

  task automatic model_write(input int a, input logic [31:0] d);
    if (a >= 16 && a < 24)  m_key[a-16] = d;
    if (a == 32 || a == 33) m_iv[a-32] = d;
    if (a >= 64 && a < 80)  m_din[a-64] = d;
    if (a == 10) m_wide = d[0];
    if (a == 11) m_rounds = d[4:0];
    if (a == 8)  m_cmd = d[1:0];
  endtask

  task automatic bus_write(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_cs = 1'b1; bus_we = 1'b1; bus_addr = a[7:0]; bus_wdata = d;
    @(negedge clk);
    bus_cs = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    model_write(a, d);
  endtask

  task automatic bus_read_check(input int a, input string tag);
    @(negedge clk);
    bus_cs = 1'b1; bus_we = 1'b0; bus_addr = a[7:0];
    #5;
    check(tag, bus_rdata, exp_rd(a));
    @(negedge clk);
    bus_cs = 1'b0; bus_addr = '0;
  endtask

  task automatic check_core_side(input string tag);
    for (int k = 0; k < 8; k++)  check({tag, " R2 key"}, core_key[255-32*k -: 32], m_key[k]);
    for (int k = 0; k < 2; k++)  check({tag, " R3 iv"}, core_iv[63-32*k -: 32], m_iv[k]);
    for (int k = 0; k < 16; k++) check({tag, " R4 din"}, core_din[511-32*k -: 32], m_din[k]);
    check({tag, " R5 wide"}, {31'd0, core_key_wide}, {31'd0, m_wide});
    check({tag, " R5 rounds"}, {27'd0, core_rounds}, {27'd0, m_rounds});
  endtask

  initial begin : watchdog
    #(20 * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 8; i++)  m_key[i] = '0;
    for (int i = 0; i < 2; i++)  m_iv[i] = '0;
    for (int i = 0; i < 16; i++) m_din[i] = '0;
    m_wide = 1'b0; m_rounds = '0; m_cmd = '0;
    for (int k = 0; k < 16; k++) core_result[511-32*k -: 32] = res_word(k);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state on core side, pulses and readback
    @(negedge clk);
    check_core_side("R1");
    check("R1 start", {31'd0, core_start}, 32'd0);
    check("R1 advance", {31'd0, core_advance}, 32'd0);
    for (int a = 0; a < 256; a++) bus_read_check(a, (a >= 128 && a < 144) ? "R8" : "R1");

    // Sweep writes to every address except the command register
    for (int a = 0; a < 256; a++)
      if (a != 8) bus_write(a, pat(a));
    @(negedge clk);
    check_core_side("sweep");

    // Full read sweep under two status combinations
    core_ready = 1'b1; core_valid = 1'b0;
    for (int a = 0; a < 256; a++) bus_read_check(a, tag_of(a));
    core_ready = 1'b0; core_valid = 1'b1;
    bus_read_check(9, "R7");
    core_ready = 1'b1; core_valid = 1'b1;
    bus_read_check(9, "R7");

    // R5: wide writes truncate
    bus_write(11, 32'hffff_ffe6);
    bus_write(10, 32'hffff_fffe);
    bus_read_check(11, "R5");
    bus_read_check(10, "R5");
    check_core_side("R5");

    // R11: write with cs low is dropped; rdata idle is 0
    @(negedge clk);
    bus_cs = 1'b0; bus_we = 1'b1; bus_addr = 8'h10; bus_wdata = 32'hdead_beef;
    #5 check("R11 idle rdata", bus_rdata, 32'd0);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    bus_read_check(16, "R11");

    // R6: start pulse lasts one cycle while the register holds the bit
    bus_write(8, 32'h1);
    #1 check("R6 start high", {31'd0, core_start}, 32'd1);
    check("R6 advance low", {31'd0, core_advance}, 32'd0);
    @(negedge clk);
    check("R6 start one cycle", {31'd0, core_start}, 32'd0);
    bus_read_check(8, "R6");
    bus_write(8, 32'h0);
    #1 check("R6 no start on clear", {31'd0, core_start}, 32'd0);
    bus_write(8, 32'h2);
    #1 check("R6 advance high", {31'd0, core_advance}, 32'd1);
    check("R6 start low", {31'd0, core_start}, 32'd0);
    @(negedge clk);
    check("R6 advance one cycle", {31'd0, core_advance}, 32'd0);
    bus_write(8, 32'hffff_ffff);
    #1 check("R6 both start", {31'd0, core_start}, 32'd1);
    check("R6 both advance", {31'd0, core_advance}, 32'd1);
    bus_read_check(8, "R6");
    check("R6 both dropped", {31'd0, core_start | core_advance}, 32'd0);
    check_core_side("R10 after cmd");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule